// File: doc/BRIEF.md
# Sleep and Watchdog Status Controller

This block sits next to a processor core in an always-on clock domain. It watches the instruction stream for the one-word sleep opcode. When that opcode runs through its four phases, the block takes the core into a low-power state by dropping the oscillator enable. It also owns two status flags, a timeout flag and a power-down flag. Software reads these flags after waking to learn how the sleep ended.

A watchdog counter advances on a tick strobe that keeps arriving while the main oscillator is stopped. A 3-bit power-of-two postscaler stretches the timeout period. A timeout during sleep wakes the core and clears the timeout flag. An external wake request wakes the core and leaves both flags as they were. A timeout while the core is running raises a one-cycle reset request instead.

The controller is a four-state machine:

- **AWAKE** is the normal run state. It moves to ARMED when the sleep opcode is valid in the first phase.
- **ARMED** is the instruction in flight. In the third phase it clears the watchdog and writes the flags. In the fourth phase it moves to ASLEEP.
- **ASLEEP** keeps the oscillator off. It moves to WAKE on a watchdog timeout or on an external wake request.
- **WAKE** lasts one cycle. It restarts the oscillator, pulses the wake output, and returns to AWAKE.

Top module: `sleep_wdt_ctrl`

## Requirements
- R1: While reset is held and right after it, osc_en=1, to_bit=1, pd_bit=1, wake_pulse=0 and wdt_rst_req=0.
- R2: Sleep starts only when instr equals 16'h0003 with instr_valid=1 while q_phase=0 (Q1). Phase codes are 0..3 for Q1..Q4. Any other word, an invalid strobe, or a match first seen in a later phase leaves the block awake.
- R3: After the edge that ends the Q3 (q_phase=2) cycle of a sleep instruction, to_bit=1 and pd_bit=0. At that edge the watchdog counter and postscaler restart from zero, and a tick in that cycle is not counted.
- R4: After the edge that ends the Q4 (q_phase=3) cycle of that instruction, osc_en=0. It stays 0 until a wake.
- R5: A watchdog timeout occurs on the tick that completes 2^WDT_CNT_W × 2^wdt_ps_sel ticks since the last clear or timeout. wdt_ps_sel is a 3-bit field giving ratios 1:1 to 1:128.
- R6: A timeout while asleep gives, after that edge, to_bit=0, pd_bit=0, osc_en=1 and wake_pulse=1 for exactly one cycle.
- R7: A wake_req while asleep with no timeout gives, after that edge, osc_en=1 and a one-cycle wake_pulse. to_bit and pd_bit are unchanged.
- R8: When a timeout and wake_req arrive in the same sleeping cycle, the timeout decides the wake cause and to_bit is cleared.
- R9: A timeout while not asleep drives wdt_rst_req to 1 for the single cycle after the timeout edge. to_bit and pd_bit are unchanged.
- R10: While asleep, instruction words, including the sleep opcode, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction word being executed |
| instr_valid | input | 1 | instr holds a valid instruction |
| q_phase | input | 2 | Phase index, 0..3 = Q1..Q4 |
| wdt_tick | input | 1 | Watchdog tick strobe, one clk wide |
| wdt_ps_sel | input | 3 | Postscaler ratio 2^sel (change only under reset) |
| wake_req | input | 1 | External wake request |
| osc_en | output | 1 | Main oscillator enable |
| to_bit | output | 1 | Timeout status flag |
| pd_bit | output | 1 | Power-down status flag |
| wake_pulse | output | 1 | One-cycle pulse on leaving sleep |
| wdt_rst_req | output | 1 | One-cycle reset request on a timeout while running |

## Verification
The hardest case to reach from the ports is a sleep instruction issued while the watchdog already holds a partial count. The stimulus first feeds twenty ticks while the core is running. It then issues the sleep instruction and counts ticks until the wake pulse appears. The count must equal the full period, which proves the Q3 clear took effect. A second case drives exactly 31 ticks into sleep and then raises the last tick together with wake_req in one cycle, to check which wake cause wins.

// File: rtl/sleep_wdt_pkg.sv
package sleep_wdt_pkg;
    localparam int INSTR_W = 16;
    localparam int PHASE_W = 2;
    localparam logic [INSTR_W-1:0] SLEEP_OPC = 16'h0003;
    localparam logic [PHASE_W-1:0] PH_Q1 = 2'd0;
    localparam logic [PHASE_W-1:0] PH_Q3 = 2'd2;
    localparam logic [PHASE_W-1:0] PH_Q4 = 2'd3;

    typedef enum logic [1:0] {
        ST_AWAKE,
        ST_ARMED,
        ST_ASLEEP,
        ST_WAKE
    } pwr_state_t;
endpackage

// File: rtl/sleep_wdt_counter.sv
module sleep_wdt_counter #(
    parameter int CNT_W = 8,
    parameter int PS_W  = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] ps_sel,
    output logic             timeout
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [PS_W-1:0]  ps_q;
    logic [PS_W-1:0]  ps_term;
    logic             at_end;

    always_comb begin
        ps_term = ~({PS_W{1'b1}} << ps_sel);
        at_end  = (cnt_q == CNT_TOP) && (ps_q == ps_term);
        timeout = tick && !clr && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ps_q  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            ps_q  <= '0;
        end else if (tick) begin
            if (cnt_q == CNT_TOP) begin
                cnt_q <= '0;
                ps_q  <= (ps_q == ps_term) ? '0 : ps_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R5
    restart_after_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (cnt_q == '0) && (ps_q == '0));

    // R3
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0) && (ps_q == '0));
endmodule

// File: rtl/sleep_wdt_fsm.sv
module sleep_wdt_fsm
    import sleep_wdt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               instr_valid,
    input  logic [PHASE_W-1:0] q_phase,
    input  logic               wake_req,
    input  logic               wdt_timeout,
    output logic               wdt_clr,
    output logic               osc_en,
    output logic               to_bit,
    output logic               pd_bit,
    output logic               wake_pulse,
    output logic               wdt_rst_req
);
    pwr_state_t state_q, state_d;
    logic       sleep_hit;

    assign sleep_hit = instr_valid && (instr == SLEEP_OPC) && (q_phase == PH_Q1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE:  if (sleep_hit) state_d = ST_ARMED;
            ST_ARMED:  if (q_phase == PH_Q4) state_d = ST_ASLEEP;
            ST_ASLEEP: if (wdt_timeout || wake_req) state_d = ST_WAKE;
            ST_WAKE:   state_d = ST_AWAKE;
            default:   state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        osc_en     = (state_q != ST_ASLEEP);
        wake_pulse = (state_q == ST_WAKE);
        wdt_clr    = (state_q == ST_ARMED) && (q_phase == PH_Q3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_bit      <= 1'b1;
            pd_bit      <= 1'b1;
            wdt_rst_req <= 1'b0;
        end else begin
            wdt_rst_req <= wdt_timeout && (state_q != ST_ASLEEP);
            if (wdt_clr) begin
                to_bit <= 1'b1;
                pd_bit <= 1'b0;
            end else if (state_q == ST_ASLEEP && wdt_timeout) begin
                to_bit <= 1'b0;
            end
        end
    end

    // R3
    to_rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_bit) |-> $past(state_q == ST_ARMED && q_phase == PH_Q3));

    // R4
    asleep_pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP) |-> !pd_bit);

    // R6
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R6
    to_fall_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(to_bit) |-> (state_q == ST_WAKE));

    // R7
    ext_wake_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && wake_req && !wdt_timeout) |=> $stable(to_bit) && $stable(pd_bit));

    // R8
    timeout_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASLEEP && wdt_timeout) |=> !to_bit && wake_pulse);

    // R9
    rst_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);
endmodule

// File: rtl/sleep_wdt_ctrl.sv
module sleep_wdt_ctrl #(
    parameter int WDT_CNT_W = 8,
    parameter int WDT_PS_W  = 7,
    parameter int WDT_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          instr,
    input  logic                 instr_valid,
    input  logic [1:0]           q_phase,
    input  logic                 wdt_tick,
    input  logic [WDT_SEL_W-1:0] wdt_ps_sel,
    input  logic                 wake_req,
    output logic                 osc_en,
    output logic                 to_bit,
    output logic                 pd_bit,
    output logic                 wake_pulse,
    output logic                 wdt_rst_req
);
    logic wdt_timeout;
    logic wdt_clr;

    sleep_wdt_counter #(
        .CNT_W (WDT_CNT_W),
        .PS_W  (WDT_PS_W),
        .SEL_W (WDT_SEL_W)
    ) wdt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (wdt_tick),
        .clr     (wdt_clr),
        .ps_sel  (wdt_ps_sel),
        .timeout (wdt_timeout)
    );

    sleep_wdt_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr       (instr),
        .instr_valid (instr_valid),
        .q_phase     (q_phase),
        .wake_req    (wake_req),
        .wdt_timeout (wdt_timeout),
        .wdt_clr     (wdt_clr),
        .osc_en      (osc_en),
        .to_bit      (to_bit),
        .pd_bit      (pd_bit),
        .wake_pulse  (wake_pulse),
        .wdt_rst_req (wdt_rst_req)
    );
endmodule

// File: tb/sleep_wdt_ctrl_tb_top.sv
module sleep_wdt_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 3;
    localparam int WATCHDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic        instr_valid = 1'b0;
    logic [1:0]  q_phase = '0;
    logic        wdt_tick = 1'b0;
    logic [2:0]  wdt_ps_sel = '0;
    logic        wake_req = 1'b0;
    logic        osc_en, to_bit, pd_bit, wake_pulse, wdt_rst_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model state: 0 awake, 1 armed, 2 asleep, 3 wake
    int m_st = 0;
    int m_ticks = 0;
    bit m_to = 1, m_pd = 1, m_rst = 0;

    sleep_wdt_ctrl #(.WDT_CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid),
        .q_phase(q_phase), .wdt_tick(wdt_tick), .wdt_ps_sel(wdt_ps_sel),
        .wake_req(wake_req), .osc_en(osc_en), .to_bit(to_bit), .pd_bit(pd_bit),
        .wake_pulse(wake_pulse), .wdt_rst_req(wdt_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int period;
        bit clr, tmo;
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_ticks = 0; m_to = 1; m_pd = 1; m_rst = 0;
        end else begin
            period = (1 << CW) * (1 << wdt_ps_sel);
            clr = (m_st == 1) && (q_phase == 2);
            tmo = wdt_tick && !clr && (m_ticks + 1 == period);
            m_rst = tmo && (m_st != 2);
            if (clr) m_ticks = 0;
            else if (wdt_tick) m_ticks = tmo ? 0 : m_ticks + 1;
            case (m_st)
                0: if (instr_valid && instr == 16'h0003 && q_phase == 0) m_st = 1;
                1: begin
                    if (q_phase == 2) begin m_to = 1; m_pd = 0; end
                    if (q_phase == 3) m_st = 2;
                end
                2: if (tmo) begin m_to = 0; m_st = 3; end
                   else if (wake_req) m_st = 3;
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R4 model osc_en", osc_en, (m_st != 2));
            check("R3 model to_bit", to_bit, m_to);
            check("R3 model pd_bit", pd_bit, m_pd);
            check("R6 model wake_pulse", wake_pulse, (m_st == 3));
            check("R9 model wdt_rst_req", wdt_rst_req, m_rst);
        end
        if (cycles > WATCHDOG_CYC && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG_CYC);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input bit tk, input bit wk, input logic [15:0] ins,
                        input bit vld, input logic [1:0] ph);
        @(negedge clk);
        wdt_tick = tk; wake_req = wk; instr = ins; instr_valid = vld; q_phase = ph;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input bit tk);
        step(tk, 1'b0, 16'h0000, 1'b0, 2'd0);
    endtask

    task automatic do_reset(input logic [2:0] sel);
        @(negedge clk);
        rst_n = 1'b0; wdt_ps_sel = sel;
        wdt_tick = 0; wake_req = 0; instr = 0; instr_valid = 0; q_phase = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic exec_sleep();
        for (int p = 0; p < 4; p++) begin
            step(1'b0, 1'b0, 16'h0003, 1'b1, 2'(p));
            if (p == 2) begin
                check("R3 to_bit after Q3", to_bit, 1);
                check("R3 pd_bit after Q3", pd_bit, 0);
            end
            if (p == 3) check("R4 osc_en after Q4", osc_en, 0);
        end
    endtask

    initial begin
        int n;
        do_reset(3'd0);
        #1;
        check("R1 osc_en", osc_en, 1);
        check("R1 to_bit", to_bit, 1);
        check("R1 pd_bit", pd_bit, 1);
        check("R1 wake_pulse", wake_pulse, 0);
        check("R1 wdt_rst_req", wdt_rst_req, 0);

        // R9: period 8 ticks at sel=0
        for (int i = 1; i <= 8; i++) begin
            idle(1'b1);
            check("R9 rst_req timing", wdt_rst_req, (i == 8));
        end
        check("R9 to_bit unchanged", to_bit, 1);
        check("R9 pd_bit unchanged", pd_bit, 1);
        idle(1'b0);
        check("R9 rst_req one cycle", wdt_rst_req, 0);

        // R2: non-matching words and phases
        for (int p = 0; p < 4; p++) step(1'b0, 1'b0, 16'h0004, 1'b1, 2'(p));
        idle(1'b0);
        check("R2 other opcode", osc_en, 1);
        for (int p = 0; p < 4; p++) step(1'b0, 1'b0, 16'h0003, 1'b0, 2'(p));
        idle(1'b0);
        check("R2 invalid strobe", osc_en, 1);
        for (int p = 1; p < 4; p++) step(1'b0, 1'b0, 16'h0003, 1'b1, 2'(p));
        idle(1'b0);
        check("R2 late phase", osc_en, 1);
        check("R2 pd_bit untouched", pd_bit, 1);

        // sleep, ignored instructions, external wake
        exec_sleep();
        for (int p = 0; p < 4; p++) step(1'b0, 1'b0, 16'h0003, 1'b1, 2'(p));
        check("R10 still asleep", osc_en, 0);
        step(1'b0, 1'b1, 16'h0000, 1'b0, 2'd0);
        check("R7 osc_en", osc_en, 1);
        check("R7 wake_pulse", wake_pulse, 1);
        check("R7 to_bit kept", to_bit, 1);
        check("R7 pd_bit kept", pd_bit, 0);
        idle(1'b0);
        check("R7 pulse one cycle", wake_pulse, 0);

        // R5/R6: sel=2, period 32, preloaded count cleared at sleep
        do_reset(3'd2);
        for (int i = 0; i < 20; i++) idle(1'b1);
        check("R9 no early reset", wdt_rst_req, 0);
        exec_sleep();
        n = 0;
        for (int i = 0; i < 200; i++) begin
            if (wake_pulse) break;
            idle(1'b1);
            n++;
        end
        check("R5 ticks to timeout", n, 32);
        check("R3 clear restarted count", n, 32);
        check("R6 to_bit cleared", to_bit, 0);
        check("R6 pd_bit low", pd_bit, 0);
        check("R6 osc_en", osc_en, 1);
        check("R6 no reset request", wdt_rst_req, 0);
        idle(1'b0);
        check("R6 pulse one cycle", wake_pulse, 0);

        // R8: simultaneous timeout and wake request
        exec_sleep();
        check("R3 to set again", to_bit, 1);
        for (int i = 0; i < 31; i++) idle(1'b1);
        check("R5 not yet timed out", osc_en, 0);
        step(1'b1, 1'b1, 16'h0000, 1'b0, 2'd0);
        check("R8 wake_pulse", wake_pulse, 1);
        check("R8 to_bit cleared", to_bit, 0);
        idle(1'b0);
        idle(1'b0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule